// File: doc/BRIEF.md
# Dual PWM Action Generator

This block turns a timer's event pulses into two pulse-width-modulated outputs. The timer reports six events, one pulse each: the counter reaching zero, compare X and compare Y matched while counting up, the counter reaching its reload value, and compare X and compare Y matched while counting down. Each output has its own 12-bit action word. That word gives every event one of four actions: hold, drive high, drive low or toggle. The output register applies the chosen action on the clock edge after the event pulse.

An output works only while its own enable and the shared timer-running input are both high. Otherwise it is held low and keeps no toggle history. A pulse on the fault input latches a fault condition. The fault forces both outputs low and blocks all events until a fault-clear strobe removes it. All control pins are plain level or pulse signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pwm_action_gen`

## Requirements
- R1: After reset both outputs are low and no fault is latched.
- R2: Event bits are evt[0] zero, evt[1] compare X up, evt[2] compare Y up, evt[3] reload, evt[4] compare X down, evt[5] compare Y down. The action for evt[k] is the field cfg[2k+1:2k] of that output's action word.
- R3: Action codes are 00 hold, 01 drive high, 10 drive low and 11 toggle. An enabled output takes the action's result on the clock edge after the event pulse.
- R4: If several events arrive in one cycle, the action of the highest-numbered event whose code is not hold wins. Events coded hold do not mask lower-numbered events.
- R5: The two outputs are independent. Each uses only its own action word and its own enable.
- R6: If an output's enable or the run input is low, that output is low from the next edge and ignores events. When re-enabled it starts from low.
- R7: A high fault_in forces both outputs low from the next edge and latches a fault. While the fault is latched, events are ignored.
- R8: fault_clr removes the latched fault at the next edge, unless fault_in is high in the same cycle, in which case the fault stays latched. After the clear, outputs restart from low.
- R9: With no event pulse, an enabled output that is free of fault keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Timer is running |
| evt | input | 6 | Event pulses, bit order as in R2 |
| cfg0 | input | 12 | Action word for pwm0 |
| cfg1 | input | 12 | Action word for pwm1 |
| en0 | input | 1 | Enable for pwm0 |
| en1 | input | 1 | Enable for pwm1 |
| fault_in | input | 1 | Fault pulse, latched |
| fault_clr | input | 1 | Strobe that clears the latched fault |
| pwm0 | output | 1 | PWM output 0 |
| pwm1 | output | 1 | PWM output 1 |

## Verification
The assertions assume that every input is a defined 0 or 1 at each sampled edge. They also assume that the action words stay steady in any cycle that carries an event pulse, so that the resolved action matches the word applied at the edge. The bench drives all inputs only on falling edges and changes the action words only in cycles without events. It holds each event pulse for exactly one cycle.

// File: rtl/pwm_act_pkg.sv
package pwm_act_pkg;
  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_HOLD = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_INV  = 2'b11
  } pwm_act_e;
endpackage

// File: rtl/pwm_act_resolve.sv
module pwm_act_resolve
  import pwm_act_pkg::*;
#(
  parameter int N_EV = 6,
  localparam int CFG_W = N_EV * ACT_W
) (
  input  logic [N_EV-1:0]  evt,
  input  logic [CFG_W-1:0] cfg,
  output pwm_act_e         act
);
  // Later events override earlier ones; hold-coded events never override.
  always_comb begin
    act = ACT_HOLD;
    for (int i = 0; i < N_EV; i++) begin
      if (evt[i] && (cfg[i*ACT_W +: ACT_W] != ACT_HOLD)) begin
        act = pwm_act_e'(cfg[i*ACT_W +: ACT_W]);
      end
    end
  end
endmodule

// File: rtl/pwm_act_channel.sv
module pwm_act_channel
  import pwm_act_pkg::*;
#(
  parameter int N_EV = 6,
  localparam int CFG_W = N_EV * ACT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EV-1:0]  evt,
  input  logic [CFG_W-1:0] cfg,
  input  logic             enable,
  input  logic             force_low,
  output logic             out
);
  pwm_act_e act;
  logic     out_q;

  pwm_act_resolve #(.N_EV(N_EV)) u_resolve (
    .evt (evt),
    .cfg (cfg),
    .act (act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (!enable || force_low) begin
      out_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_HIGH: out_q <= 1'b1;
        ACT_LOW:  out_q <= 1'b0;
        ACT_INV:  out_q <= ~out_q;
        default:  out_q <= out_q;
      endcase
    end
  end

  assign out = out_q;

  // R6: disabled output goes low on the next edge
  a_r6_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_q);
  // R7: forced low by a fault
  a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !out_q);
  // R9: no event keeps the level
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !force_low && evt == '0) |=> $stable(out_q));
  // R3: toggle flips the output
  a_r3_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !force_low && act == ACT_INV) |=> (out_q != $past(out_q)));
  // R3: drive-high action
  a_r3_high: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !force_low && act == ACT_HIGH) |=> out_q);
endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic fault_clr,
  output logic fault_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_in | (fault_q & ~fault_clr);
  end

  // R7: a fault pulse latches
  a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> fault_q);
  // R7: latched fault stays without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);
  // R8: clear without a new fault releases the latch
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !fault_in) |=> !fault_q);
endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
  import pwm_act_pkg::*;
#(
  parameter int N_EV = 6,
  localparam int CFG_W = N_EV * ACT_W,
  localparam int N_CH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [N_EV-1:0]  evt,
  input  logic [CFG_W-1:0] cfg0,
  input  logic [CFG_W-1:0] cfg1,
  input  logic             en0,
  input  logic             en1,
  input  logic             fault_in,
  input  logic             fault_clr,
  output logic             pwm0,
  output logic             pwm1
);
  logic             fault_q;
  logic             force_low;
  logic [CFG_W-1:0] cfg_arr [N_CH];
  logic [N_CH-1:0]  en_arr;
  logic [N_CH-1:0]  pwm_arr;

  pwm_fault_latch u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_in  (fault_in),
    .fault_clr (fault_clr),
    .fault_q   (fault_q)
  );

  assign force_low  = fault_q | fault_in;
  assign cfg_arr[0] = cfg0;
  assign cfg_arr[1] = cfg1;
  assign en_arr     = {en1, en0};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_act_channel #(.N_EV(N_EV)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .cfg       (cfg_arr[c]),
      .enable    (en_arr[c] & run),
      .force_low (force_low),
      .out       (pwm_arr[c])
    );
  end

  assign pwm0 = pwm_arr[0];
  assign pwm1 = pwm_arr[1];

  // R1: both outputs low on the edge after reset
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> (!pwm0 && !pwm1));
  // R6: timer stopped forces both outputs low
  a_r6_run_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pwm0 && !pwm1));
endmodule

// File: tb/tb_pwm_action_gen.sv
module tb_pwm_action_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [5:0]  evt = '0;
  logic [11:0] cfg0 = '0;
  logic [11:0] cfg1 = '0;
  logic        en0 = 1'b0;
  logic        en1 = 1'b0;
  logic        fault_in = 1'b0;
  logic        fault_clr = 1'b0;
  logic        pwm0, pwm1;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pwm_action_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .evt(evt),
    .cfg0(cfg0), .cfg1(cfg1), .en0(en0), .en1(en1),
    .fault_in(fault_in), .fault_clr(fault_clr),
    .pwm0(pwm0), .pwm1(pwm1)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle of events; outputs are settled at the following falling edge.
  task automatic pulse(input logic [5:0] e);
    @(negedge clk) evt = e;
    @(negedge clk) evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 pwm0 after reset", pwm0, 1'b0);
    chk("R1 pwm1 after reset", pwm1, 1'b0);
    @(negedge clk) begin rst_n = 1'b1; run = 1'b1; en0 = 1'b1; en1 = 1'b1; end
  endtask

  task automatic t_basic;
    @(negedge clk) begin cfg0 = 12'h009; cfg1 = 12'h000; end
    pulse(6'b000001);
    chk("R2 zero event drives high", pwm0, 1'b1);
    chk("R5 pwm1 untouched by cfg0", pwm1, 1'b0);
    pulse(6'b000010);
    chk("R2 compare X up drives low", pwm0, 1'b0);
  endtask

  task automatic t_invert;
    @(negedge clk) cfg0 = 12'h0C0;
    pulse(6'b001000);
    chk("R3 reload toggle to high", pwm0, 1'b1);
    pulse(6'b001000);
    chk("R3 reload toggle to low", pwm0, 1'b0);
  endtask

  task automatic t_priority;
    @(negedge clk) cfg0 = 12'h801;
    pulse(6'b000001);
    chk("R4 setup high", pwm0, 1'b1);
    pulse(6'b100001);
    chk("R4 compare Y down beats zero", pwm0, 1'b0);
    @(negedge clk) cfg0 = 12'h002;
    pulse(6'b000001);
    chk("R4 setup low", pwm0, 1'b0);
    @(negedge clk) cfg0 = 12'h001;
    pulse(6'b001001);
    chk("R4 hold-coded reload does not mask zero", pwm0, 1'b1);
  endtask

  task automatic t_hold;
    idle(5);
    chk("R9 level kept without events", pwm0, 1'b1);
    @(negedge clk) cfg0 = 12'h000;
    pulse(6'b111111);
    chk("R3 all-hold word keeps level", pwm0, 1'b1);
  endtask

  task automatic t_indep;
    @(negedge clk) begin cfg0 = 12'h000; cfg1 = 12'h030; end
    pulse(6'b000100);
    chk("R5 pwm1 toggles on compare Y up", pwm1, 1'b1);
    chk("R5 pwm0 unaffected", pwm0, 1'b1);
  endtask

  task automatic t_disable;
    @(negedge clk) en1 = 1'b0;
    @(negedge clk);
    chk("R6 disabled pwm1 low", pwm1, 1'b0);
    pulse(6'b000100);
    chk("R6 disabled pwm1 ignores events", pwm1, 1'b0);
    @(negedge clk) en1 = 1'b1;
    @(negedge clk);
    chk("R6 re-enabled pwm1 starts low", pwm1, 1'b0);
    pulse(6'b000100);
    chk("R6 toggle from low after re-enable", pwm1, 1'b1);
    @(negedge clk) run = 1'b0;
    @(negedge clk);
    chk("R6 run low clears pwm0", pwm0, 1'b0);
    chk("R6 run low clears pwm1", pwm1, 1'b0);
    @(negedge clk) run = 1'b1;
  endtask

  task automatic t_fault;
    @(negedge clk) begin cfg0 = 12'h001; cfg1 = 12'h001; end
    pulse(6'b000001);
    chk("R7 setup pwm0 high", pwm0, 1'b1);
    @(negedge clk) fault_in = 1'b1;
    @(negedge clk) fault_in = 1'b0;
    chk("R7 fault forces pwm0 low", pwm0, 1'b0);
    chk("R7 fault forces pwm1 low", pwm1, 1'b0);
    pulse(6'b000001);
    chk("R7 latched fault ignores events", pwm0, 1'b0);
    @(negedge clk) begin fault_in = 1'b1; fault_clr = 1'b1; end
    @(negedge clk) begin fault_in = 1'b0; fault_clr = 1'b0; end
    pulse(6'b000001);
    chk("R8 fault wins over same-cycle clear", pwm1, 1'b0);
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
    chk("R8 output low right after clear", pwm0, 1'b0);
    pulse(6'b000001);
    chk("R8 events resume after clear", pwm0, 1'b1);
    chk("R8 pwm1 resumes after clear", pwm1, 1'b1);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_invert();
    t_priority();
    t_hold();
    t_indep();
    t_disable();
    t_fault();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule